// File: doc/BRIEF.md
# Receive Destination Address Filter

This block decides, for every incoming Ethernet frame, whether the frame is kept or dropped, using only the 48-bit destination address and the frame length. Two exact-match unicast slots, a broadcast enable and a 64-bin group hash table are programmed through 32-bit register writes. The surrounding receive path presents the destination address, the length and a one-cycle valid strobe. One cycle later the filter raises a done pulse together with the keep or drop verdict.

The group hash folds the address bit stream into a 6-bit bin number. Bits are taken in wire order: byte 0 first, and the least significant bit first within each byte. The stream is cut into eight 6-bit pieces, and the eight pieces are XORed together. A set bit in the table for that bin lets the frame through. By default only group addresses (first address bit set) may use the table. A control bit lets individual addresses use it too.

The controller has two states. `IDLE` waits for a strobe. The transition `IDLE -> EVAL` is taken on a strobe, and the address and length are captured on that edge. `EVAL` presents the verdict with done high. From `EVAL`, the transition `EVAL -> EVAL` is taken when a new strobe arrives in that cycle, and the transition `EVAL -> IDLE` is taken otherwise. `IDLE -> IDLE` holds while no strobe arrives.

Top module: `rx_dst_filter`

## Requirements
- R1: After reset, `dec_done` and `dec_accept` are 0 until a frame is presented.
- R2: A frame strobed by `frm_valid` in cycle N has `dec_done` high in cycle N+1 only, unless another strobe arrives in cycle N+1. `dec_accept` is never high while `dec_done` is low.
- R3: Register offsets 0/1 hold unicast slot 0 and offsets 2/3 hold unicast slot 1. In each low register, address byte k sits in bits 8k+7:8k for k = 0..3. In each high register, byte 4 sits in bits 7:0 and byte 5 in bits 15:8. Control register (offset 6) bit 0 enables slot 0 and bit 1 enables slot 1. A frame whose address equals an enabled slot is accepted; a disabled slot never matches.
- R4: With control bit 3 set, an all-ones destination address is accepted. With control bit 3 clear, broadcast alone does not accept the frame.
- R5: The hash bin is the XOR of the eight 6-bit pieces of the address stream. `frm_dst` carries byte k in bits 8k+7:8k, so stream bit i is `frm_dst[i]`.
- R6: Bins 0..31 select that bit of the group-low register (offset 4). Bins 32..63 select bit (bin-32) of the group-high register (offset 5). A set bit accepts the frame.
- R7: With control bit 2 clear and bit 0 of address byte 0 equal to 0, the hash table never accepts the frame. With control bit 2 set, such an address is hashed like a group address.
- R8: A frame with `frm_len` below 12 is dropped whatever its address; a length of exactly 12 is judged normally.
- R9: A register write is used by any frame whose strobe arrives in a later cycle than the write. Control bits other than 0..3 and register offset 7 have no effect on the verdict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register word offset |
| cfg_wdata | input | 32 | Register write data |
| frm_valid | input | 1 | Frame strobe, one cycle |
| frm_dst | input | 48 | Destination address, byte k in bits 8k+7:8k |
| frm_len | input | 16 | Frame length in bytes |
| dec_done | output | 1 | Verdict valid pulse |
| dec_accept | output | 1 | Frame kept when high with dec_done |

## Verification
The hardest case to reach is a hash hit in a chosen bin, and in particular a bin in the upper half. The bench handles this with its own bit-stream model of the bin. It scans candidate addresses until one falls in the wanted half, programs exactly that table bit, and then clears the bit again to show the drop. The same model is used on a unicast address with the individual-hash control bit toggled, and on back-to-back strobes that keep `EVAL` occupied for two cycles.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
    typedef enum logic {
        S_IDLE = 1'b0,
        S_EVAL = 1'b1
    } rxf_state_t;

    localparam logic [2:0] OFS_UC0_LO = 3'd0;
    localparam logic [2:0] OFS_UC0_HI = 3'd1;
    localparam logic [2:0] OFS_UC1_LO = 3'd2;
    localparam logic [2:0] OFS_UC1_HI = 3'd3;
    localparam logic [2:0] OFS_GRP_LO = 3'd4;
    localparam logic [2:0] OFS_GRP_HI = 3'd5;
    localparam logic [2:0] OFS_CTRL   = 3'd6;

    localparam int CB_UC0   = 0;
    localparam int CB_UC1   = 1;
    localparam int CB_INDIV = 2;
    localparam int CB_BCAST = 3;
endpackage

// File: rtl/rxf_cfg_regs.sv
module rxf_cfg_regs
    import rxf_pkg::*;
#(
    parameter int ADDR_W = 48,
    parameter int DATA_W = 32,
    parameter int GRP_W  = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [ADDR_W-1:0] uc0,
    output logic [ADDR_W-1:0] uc1,
    output logic [GRP_W-1:0]  grp_tbl,
    output logic [3:0]        ctrl
);
    localparam int HI_W  = ADDR_W - DATA_W;
    localparam int GHALF = GRP_W / 2;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            uc0     <= '0;
            uc1     <= '0;
            grp_tbl <= '0;
            ctrl    <= '0;
        end else if (cfg_we) begin
            unique case (cfg_addr)
                OFS_UC0_LO: uc0[DATA_W-1:0]        <= cfg_wdata;
                OFS_UC0_HI: uc0[ADDR_W-1:DATA_W]   <= cfg_wdata[HI_W-1:0];
                OFS_UC1_LO: uc1[DATA_W-1:0]        <= cfg_wdata;
                OFS_UC1_HI: uc1[ADDR_W-1:DATA_W]   <= cfg_wdata[HI_W-1:0];
                OFS_GRP_LO: grp_tbl[GHALF-1:0]     <= cfg_wdata[GHALF-1:0];
                OFS_GRP_HI: grp_tbl[GRP_W-1:GHALF] <= cfg_wdata[GHALF-1:0];
                OFS_CTRL:   ctrl                   <= cfg_wdata[3:0];
                default:    ;
            endcase
        end
    end
endmodule

// File: rtl/rxf_hash.sv
module rxf_hash #(
    parameter int ADDR_W = 48,
    parameter int HASH_W = 6
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [HASH_W-1:0] bin
);
    localparam int NSL = ADDR_W / HASH_W;

    logic [HASH_W-1:0] fold [NSL+1];

    assign fold[0] = '0;
    for (genvar g = 0; g < NSL; g++) begin : g_slice
        assign fold[g+1] = fold[g] ^ addr[g*HASH_W +: HASH_W];
    end
    assign bin = fold[NSL];
endmodule

// File: rtl/rxf_match.sv
module rxf_match
    import rxf_pkg::*;
#(
    parameter int ADDR_W  = 48,
    parameter int LEN_W   = 16,
    parameter int HASH_W  = 6,
    parameter int MIN_LEN = 12
) (
    input  logic [ADDR_W-1:0]      dst,
    input  logic [LEN_W-1:0]       len,
    input  logic [ADDR_W-1:0]      uc0,
    input  logic [ADDR_W-1:0]      uc1,
    input  logic [(1<<HASH_W)-1:0] grp_tbl,
    input  logic [3:0]             ctrl,
    output logic                   keep
);
    logic [HASH_W-1:0] bin;
    logic hit_uc0, hit_uc1, hit_bc, hit_grp, hash_ok, len_ok;

    rxf_hash #(.ADDR_W(ADDR_W), .HASH_W(HASH_W)) u_hash (
        .addr (dst),
        .bin  (bin)
    );

    always_comb begin
        hit_uc0 = ctrl[CB_UC0] && (dst == uc0);
        hit_uc1 = ctrl[CB_UC1] && (dst == uc1);
        hit_bc  = ctrl[CB_BCAST] && (&dst);
        hash_ok = ctrl[CB_INDIV] || dst[0];
        hit_grp = hash_ok && grp_tbl[bin];
        len_ok  = (len >= LEN_W'(MIN_LEN));
        keep    = len_ok && (hit_uc0 || hit_uc1 || hit_bc || hit_grp);
    end
endmodule

// File: rtl/rx_dst_filter.sv
module rx_dst_filter
    import rxf_pkg::*;
#(
    parameter int ADDR_W  = 48,
    parameter int DATA_W  = 32,
    parameter int LEN_W   = 16,
    parameter int HASH_W  = 6,
    parameter int MIN_LEN = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic              frm_valid,
    input  logic [ADDR_W-1:0] frm_dst,
    input  logic [LEN_W-1:0]  frm_len,
    output logic              dec_done,
    output logic              dec_accept
);
    localparam int GRP_W = 1 << HASH_W;

    rxf_state_t state, state_nx;
    logic [ADDR_W-1:0] cap_dst;
    logic [LEN_W-1:0]  cap_len;
    logic [ADDR_W-1:0] uc0, uc1;
    logic [GRP_W-1:0]  grp_tbl;
    logic [3:0]        ctrl;
    logic              keep;

    rxf_cfg_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .GRP_W(GRP_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .uc0       (uc0),
        .uc1       (uc1),
        .grp_tbl   (grp_tbl),
        .ctrl      (ctrl)
    );

    rxf_match #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .HASH_W(HASH_W), .MIN_LEN(MIN_LEN)) u_match (
        .dst     (cap_dst),
        .len     (cap_len),
        .uc0     (uc0),
        .uc1     (uc1),
        .grp_tbl (grp_tbl),
        .ctrl    (ctrl),
        .keep    (keep)
    );

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE: state_nx = frm_valid ? S_EVAL : S_IDLE;
            S_EVAL: state_nx = frm_valid ? S_EVAL : S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            cap_dst <= '0;
            cap_len <= '0;
        end else begin
            state <= state_nx;
            if (frm_valid) begin
                cap_dst <= frm_dst;
                cap_len <= frm_len;
            end
        end
    end

    always_comb begin
        dec_done   = 1'b0;
        dec_accept = 1'b0;
        unique case (state)
            S_IDLE: ;
            S_EVAL: begin
                dec_done   = 1'b1;
                dec_accept = keep;
            end
            default: ;
        endcase
    end

    // R2
    done_after_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frm_valid |=> dec_done);
    // R2
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frm_valid |=> !dec_done);
    // R2
    accept_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec_accept |-> dec_done);
    // R8
    short_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_valid && frm_len < LEN_W'(MIN_LEN)) |=> !dec_accept);
    // R4
    bcast_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_valid && (&frm_dst) && frm_len >= LEN_W'(MIN_LEN)
         && ctrl[CB_BCAST] && !cfg_we) |=> dec_accept);
endmodule

// File: tb/rx_dst_filter_tb.sv
module rx_dst_filter_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        frm_valid = 1'b0;
    logic [47:0] frm_dst = '0;
    logic [15:0] frm_len = '0;
    logic        dec_done, dec_accept;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    rx_dst_filter u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .frm_valid(frm_valid), .frm_dst(frm_dst),
        .frm_len(frm_len), .dec_done(dec_done), .dec_accept(dec_accept)
    );

    function automatic logic [47:0] mk(input logic [7:0] b0, b1, b2, b3, b4, b5);
        return {b5, b4, b3, b2, b1, b0};
    endfunction

    function automatic int model_bin(input logic [47:0] a);
        logic [7:0] bytes [6];
        logic [5:0] acc = '0;
        for (int k = 0; k < 6; k++) bytes[k] = a[8*k +: 8];
        for (int i = 0; i < 48; i++) acc[i % 6] = acc[i % 6] ^ bytes[i / 8][i % 8];
        return int'(acc);
    endfunction

    task automatic check(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] ofs, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = ofs; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic set_uc(input int slot, input logic [47:0] a);
        wr(3'(2*slot), a[31:0]);
        wr(3'(2*slot+1), {16'h0, a[47:32]});
    endtask

    task automatic frame(input logic [47:0] a, input logic [15:0] len, input logic exp, input string req);
        frm_valid = 1'b1; frm_dst = a; frm_len = len;
        @(negedge clk);
        frm_valid = 1'b0;
        check(req, dec_done, 1'b1);
        check(req, dec_accept, exp);
        @(negedge clk);
        check({req, " done pulse"}, dec_done, 1'b0);
    endtask

    task automatic t_reset();
        check("R1 done", dec_done, 1'b0);
        check("R1 accept", dec_accept, 1'b0);
    endtask

    task automatic t_unicast();
        logic [47:0] a0 = mk(8'h02, 8'h10, 8'h20, 8'h30, 8'h40, 8'h50);
        logic [47:0] a1 = mk(8'h06, 8'hA1, 8'hB2, 8'hC3, 8'hD4, 8'hE5);
        set_uc(0, a0);
        set_uc(1, a1);
        wr(3'd6, 32'h0);
        frame(a0, 16'd64, 1'b0, "R3 slot0 disabled");
        wr(3'd6, 32'h1);
        frame(a0, 16'd64, 1'b1, "R3 slot0 match");
        frame(a1, 16'd64, 1'b0, "R3 slot1 disabled");
        frame(a0 ^ 48'h1000_0000_0000, 16'd64, 1'b0, "R3 slot0 byte5 differs");
        wr(3'd6, 32'hFFFF_FFF2);
        frame(a1, 16'd64, 1'b1, "R3 slot1 match");
        frame(a0, 16'd64, 1'b0, "R9 slot0 off after write");
    endtask

    task automatic t_bcast();
        wr(3'd6, 32'h0);
        frame('1, 16'd64, 1'b0, "R4 broadcast off");
        wr(3'd6, 32'h8);
        frame('1, 16'd64, 1'b1, "R4 broadcast on");
        wr(3'd7, 32'h0);
        frame('1, 16'd64, 1'b1, "R9 offset 7 no effect");
    endtask

    task automatic t_hash_low_high();
        logic [47:0] g = mk(8'h01, 8'h00, 8'h5E, 8'h00, 8'h00, 8'hFB);
        int b;
        wr(3'd6, 32'h0);
        for (int v = 0; v < 256; v++) begin
            g[47:40] = 8'(v);
            if (model_bin(g) < 32) break;
        end
        b = model_bin(g);
        frame(g, 16'd64, 1'b0, "R5 group bin clear");
        wr(3'd4, 32'h1 << b);
        frame(g, 16'd64, 1'b1, "R5 R6 group bin low hit");
        wr(3'd4, ~(32'h1 << b));
        frame(g, 16'd64, 1'b0, "R6 only own bin counts");
        wr(3'd4, 32'h0);
        for (int v = 0; v < 256; v++) begin
            g[47:40] = 8'(v);
            if (model_bin(g) >= 32) break;
        end
        b = model_bin(g);
        wr(3'd5, 32'h1 << (b - 32));
        frame(g, 16'd64, 1'b1, "R6 group bin high hit");
        wr(3'd5, 32'h0);
        frame(g, 16'd64, 1'b0, "R6 group bin high cleared");
    endtask

    task automatic t_indiv();
        logic [47:0] u = mk(8'h02, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55);
        int b = model_bin(u);
        if (b < 32) wr(3'd4, 32'h1 << b); else wr(3'd5, 32'h1 << (b - 32));
        wr(3'd6, 32'h0);
        frame(u, 16'd64, 1'b0, "R7 individual not hashed");
        wr(3'd6, 32'h4);
        frame(u, 16'd64, 1'b1, "R7 individual hashed");
        wr(3'd4, 32'h0);
        wr(3'd5, 32'h0);
    endtask

    task automatic t_length();
        wr(3'd6, 32'h8);
        frame('1, 16'd11, 1'b0, "R8 length 11 dropped");
        frame('1, 16'd0, 1'b0, "R8 length 0 dropped");
        frame('1, 16'd12, 1'b1, "R8 length 12 judged");
    endtask

    task automatic t_back_to_back();
        wr(3'd6, 32'h8);
        frm_valid = 1'b1; frm_dst = '1; frm_len = 16'd64;
        @(negedge clk);
        frm_dst = 48'h0000_0000_0002;
        check("R2 b2b first done", dec_done, 1'b1);
        check("R2 b2b first accept", dec_accept, 1'b1);
        @(negedge clk);
        frm_valid = 1'b0;
        check("R2 b2b second done", dec_done, 1'b1);
        check("R2 b2b second drop", dec_accept, 1'b0);
        @(negedge clk);
        check("R2 b2b idle", dec_done, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_unicast();
        t_bcast();
        t_hash_low_high();
        t_indiv();
        t_length();
        t_back_to_back();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule